// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block sits between a register bus and the serializer of a serial audio transmitter. Software pushes 32-bit sample words one at a time by writing a data register. The serializer pulls words from the head of the queue with a one-cycle pop request, and the word is handed over in that same cycle. The current fill level can be read back at any time. A watermark comparison tells software or a DMA engine that there is room to refill the queue. A sticky flag records any cycle in which the serializer wanted a sample while the queue was empty.

A small controller decides whether the serializer may draw samples at all, and it also runs the flush sequence. It has three states. `ST_IDLE` means transmission is stopped and pops are refused. `ST_RUN` means pops are served. `ST_FLUSH` lasts one cycle, during which the queue is emptied.

The transitions are these. `ST_IDLE` goes to `ST_RUN` when the start bit is written as 1. `ST_RUN` goes to `ST_IDLE` when the start bit is written as 0. Either of those states goes to `ST_FLUSH` when the flush bit is written, and a flush request takes precedence over a start or stop. `ST_FLUSH` goes to `ST_RUN` when the start bit is set, and to `ST_IDLE` otherwise.

The interrupt line and the DMA request are level outputs computed from the current fill level and the sticky flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the fill level reads 0 and every control field reads 0. The status register reads 0x1, because level 0 is at or below watermark 0. `irq`, `dma_req` and `ser_ack` are low.
- R2: Each bus write to offset 0x18 pushes `bus_wdata` as one word. Accepted pops return words in write order on `ser_data` with `ser_ack` high. The level reads in bits 5:0 of offset 0x14.
- R3: The queue holds 32 words. A push while the level is 32 is dropped, and the level stays at 32.
- R4: Bit 0 of offset 0x08 starts transmission. While it is 0, `ser_pop` is never acknowledged, the level does not change and no underrun is recorded.
- R5: Status bit 0 (offset 0x04) is high exactly while level ≤ watermark. The watermark is bits 8:4 of offset 0x00. This status is not sticky.
- R6: Status bit 1 sets when `ser_pop` is asserted while running with an empty queue. It stays set until bit 2 of offset 0x00 is written as 1. That bit is a strobe and reads 0. If an underrun and a clear happen in the same cycle, the underrun wins.
- R7: `irq` is the OR of (status bit 0 AND enable bit 0) and (status bit 1 AND enable bit 1), with both enables in offset 0x00.
- R8: Writing 1 to bit 0 of offset 0x0C empties the queue. That bit reads 1 in the cycle after the write and 0 from the following cycle on, and by then the level reads 0.
- R9: `dma_req` is high when bit 8 of offset 0x10 is set and the level is ≤ bits 4:0 of offset 0x10.
- R10: A push and an accepted pop in the same cycle, with the queue not full, leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ser_pop | input | 1 | Serializer requests one sample |
| ser_ack | output | 1 | Request served this cycle; `ser_data` is valid |
| ser_data | output | 32 | Head word of the queue |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA refill request |

## Verification
A corrupted read pointer or a corrupted word shows up on `ser_data` at the very next acknowledged pop. A wrong level count shows up at once in the level register, in the threshold status and in `dma_req`, and a drift is seen at the next full or empty boundary, where pushes are dropped or pops refused at the wrong point. A controller stuck in the wrong state shows up in the cycle after the start or flush write, as a refused or wrongly granted pop, or as a flush bit that does not return to 0. A lost sticky flag shows up in the next status read after the underrun event.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } tx_state_e;

    // register byte offsets
    localparam logic [5:0] OFS_IRQ_CTRL = 6'h00;
    localparam logic [5:0] OFS_IRQ_STAT = 6'h04;
    localparam logic [5:0] OFS_XFER     = 6'h08;
    localparam logic [5:0] OFS_FLUSH    = 6'h0C;
    localparam logic [5:0] OFS_DMA      = 6'h10;
    localparam logic [5:0] OFS_LEVEL    = 6'h14;
    localparam logic [5:0] OFS_DATA     = 6'h18;

    // field positions
    localparam int BIT_THR_EN  = 0;
    localparam int BIT_UND_EN  = 1;
    localparam int BIT_UND_CLR = 2;
    localparam int WM_LSB      = 4;
    localparam int BIT_DMA_EN  = 8;
    localparam int BIT_THR_ST  = 0;
    localparam int BIT_UND_ST  = 1;

endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [LW-1:0] count;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign level    = count;

endmodule

// File: rtl/tx_ctl_fsm.sv
module tx_ctl_fsm
    import audio_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_req,
    input  logic      flush_req,
    output tx_state_e state,
    output logic      running,
    output logic      flushing
);
    tx_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (flush_req)    state_nx = ST_FLUSH;
                else if (run_req) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (flush_req)     state_nx = ST_FLUSH;
                else if (!run_req) state_nx = ST_IDLE;
            end
            ST_FLUSH: begin
                if (flush_req)    state_nx = ST_FLUSH;
                else if (run_req) state_nx = ST_RUN;
                else              state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running  = 1'b0;
        flushing = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_RUN:   running  = 1'b1;
            ST_FLUSH: flushing = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tx_regs.sv
module tx_regs
    import audio_tx_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int LW   = 6,
    parameter int WM_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [LW-1:0]   level,
    input  logic            thr_st,
    input  logic            und_st,
    input  logic            flushing,
    output logic            push_req,
    output logic            flush_req,
    output logic            run_req,
    output logic            und_clr,
    output logic            thr_en,
    output logic            und_en,
    output logic [WM_W-1:0] wm,
    output logic            dma_en,
    output logic [WM_W-1:0] dma_lvl
);
    logic wr_ctrl;
    logic wr_xfer;
    logic wr_flush;
    logic wr_dma;
    logic xfer_en;

    assign wr_ctrl  = bus_wr && (bus_addr == AW'(OFS_IRQ_CTRL));
    assign wr_xfer  = bus_wr && (bus_addr == AW'(OFS_XFER));
    assign wr_flush = bus_wr && (bus_addr == AW'(OFS_FLUSH));
    assign wr_dma   = bus_wr && (bus_addr == AW'(OFS_DMA));
    assign push_req = bus_wr && (bus_addr == AW'(OFS_DATA));

    assign flush_req = wr_flush && bus_wdata[0];
    assign und_clr   = wr_ctrl && bus_wdata[BIT_UND_CLR];
    assign run_req   = wr_xfer ? bus_wdata[0] : xfer_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_en  <= 1'b0;
            und_en  <= 1'b0;
            wm      <= '0;
            dma_en  <= 1'b0;
            dma_lvl <= '0;
            xfer_en <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                thr_en <= bus_wdata[BIT_THR_EN];
                und_en <= bus_wdata[BIT_UND_EN];
                wm     <= bus_wdata[WM_LSB +: WM_W];
            end
            if (wr_dma) begin
                dma_en  <= bus_wdata[BIT_DMA_EN];
                dma_lvl <= bus_wdata[WM_W-1:0];
            end
            if (wr_xfer) begin
                xfer_en <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_IRQ_CTRL): begin
                bus_rdata[BIT_THR_EN]        = thr_en;
                bus_rdata[BIT_UND_EN]        = und_en;
                bus_rdata[WM_LSB +: WM_W]    = wm;
            end
            AW'(OFS_IRQ_STAT): begin
                bus_rdata[BIT_THR_ST] = thr_st;
                bus_rdata[BIT_UND_ST] = und_st;
            end
            AW'(OFS_XFER):  bus_rdata[0] = xfer_en;
            AW'(OFS_FLUSH): bus_rdata[0] = flushing;
            AW'(OFS_DMA): begin
                bus_rdata[BIT_DMA_EN] = dma_en;
                bus_rdata[WM_W-1:0]   = dma_lvl;
            end
            AW'(OFS_LEVEL): bus_rdata[LW-1:0] = level;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tx_irq_gen.sv
module tx_irq_gen #(
    parameter int LW   = 6,
    parameter int WM_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   level,
    input  logic [WM_W-1:0] wm,
    input  logic            thr_en,
    input  logic            und_en,
    input  logic            und_evt,
    input  logic            und_clr,
    input  logic            dma_en,
    input  logic [WM_W-1:0] dma_lvl,
    output logic            thr_st,
    output logic            und_st,
    output logic            irq,
    output logic            dma_req
);
    assign thr_st = (level <= LW'(wm));

    // sticky underrun; a new event beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            und_st <= 1'b0;
        end else if (und_evt) begin
            und_st <= 1'b1;
        end else if (und_clr) begin
            und_st <= 1'b0;
        end
    end

    assign irq     = (thr_st && thr_en) || (und_st && und_en);
    assign dma_req = dma_en && (level <= LW'(dma_lvl));

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audio_tx_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ser_pop,
    output logic          ser_ack,
    output logic [DW-1:0] ser_data,
    output logic          irq,
    output logic          dma_req
);
    localparam int LW   = $clog2(DEPTH + 1);
    localparam int WM_W = $clog2(DEPTH);

    tx_state_e       state;
    logic            running;
    logic            flushing;
    logic            push_req;
    logic            flush_req;
    logic            run_req;
    logic            und_clr;
    logic            und_evt;
    logic            thr_en;
    logic            und_en;
    logic            dma_en;
    logic [WM_W-1:0] wm;
    logic [WM_W-1:0] dma_lvl;
    logic [LW-1:0]   level_w;
    logic            full_w;
    logic            empty_w;
    logic            thr_st;
    logic            und_st;
    logic            pop_go;

    assign pop_go  = ser_pop && running;
    assign ser_ack = pop_go && !empty_w;
    assign und_evt = pop_go && empty_w;

    tx_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (run_req),
        .flush_req (flush_req),
        .state     (state),
        .running   (running),
        .flushing  (flushing)
    );

    tx_regs #(.AW(AW), .DW(DW), .LW(LW), .WM_W(WM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level_w),
        .thr_st    (thr_st),
        .und_st    (und_st),
        .flushing  (flushing),
        .push_req  (push_req),
        .flush_req (flush_req),
        .run_req   (run_req),
        .und_clr   (und_clr),
        .thr_en    (thr_en),
        .und_en    (und_en),
        .wm        (wm),
        .dma_en    (dma_en),
        .dma_lvl   (dma_lvl)
    );

    tx_fifo_store #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flushing),
        .push      (push_req),
        .push_data (bus_wdata),
        .pop       (pop_go),
        .pop_data  (ser_data),
        .level     (level_w),
        .full      (full_w),
        .empty     (empty_w)
    );

    tx_irq_gen #(.LW(LW), .WM_W(WM_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level_w),
        .wm      (wm),
        .thr_en  (thr_en),
        .und_en  (und_en),
        .und_evt (und_evt),
        .und_clr (und_clr),
        .dma_en  (dma_en),
        .dma_lvl (dma_lvl),
        .thr_st  (thr_st),
        .und_st  (und_st),
        .irq     (irq),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk
    import audio_tx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input tx_state_e     state,
    input logic [LW-1:0] level,
    input logic          push_req,
    input logic          ser_ack,
    input logic          und_st,
    input logic          und_clr,
    input logic          dma_en,
    input logic          dma_req
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && push_req && !ser_ack) |=> (level == LW'(DEPTH))); // R3

    AST_ACK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ack |-> (level != '0)); // R2

    AST_ACK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ack |-> (state == ST_RUN)); // R4

    AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (und_st && !und_clr) |=> und_st); // R6

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> (level == '0)); // R8

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req); // R9

    AST_PAIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && ser_ack && level < LW'(DEPTH)) |=> $stable(level)); // R10

endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .level    (level_w),
    .push_req (push_req),
    .ser_ack  (ser_ack),
    .und_st   (und_st),
    .und_clr  (und_clr),
    .dma_en   (dma_en),
    .dma_req  (dma_req)
);

// File: tb/audio_tx_fifo_tb_top.sv
`timescale 1ns/1ps
module audio_tx_fifo_tb_top;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_pop = 1'b0;
    logic        ser_ack;
    logic [31:0] ser_data;
    logic        irq;
    logic        dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] q[$];
    bit run_m = 0, und_m = 0, thr_en_m = 0, und_en_m = 0, dma_en_m = 0;
    int wm_m = 0, dma_lvl_m = 0;

    always #4 clk = ~clk;

    audio_tx_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_pop(ser_pop),
        .ser_ack(ser_ack), .ser_data(ser_data), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        return (thr_en_m && (q.size() <= wm_m)) || (und_en_m && und_m);
    endfunction

    function automatic bit exp_dma();
        return dma_en_m && (q.size() <= dma_lvl_m);
    endfunction

    // every task starts and ends at a falling edge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic push_w(input logic [31:0] d);
        bus_write(6'h18, d);
        if (q.size() < DEPTH) q.push_back(d);
    endtask

    task automatic ctrl_write(input int wm, input bit te, input bit ue, input bit clr);
        bus_write(6'h00, (32'(wm) << 4) | (32'(clr) << 2) | (32'(ue) << 1) | 32'(te));
        wm_m = wm; thr_en_m = te; und_en_m = ue;
        if (clr) und_m = 0;
    endtask

    task automatic pop_chk(input string tag);
        bit exp_ack;
        exp_ack = run_m && (q.size() > 0);
        ser_pop = 1'b1;
        #1;
        chk({tag, " ack"}, 32'(ser_ack), 32'(exp_ack));
        if (exp_ack) begin
            chk({tag, " data"}, ser_data, q[0]);
            void'(q.pop_front());
        end else if (run_m) begin
            und_m = 1;
        end
        @(negedge clk);
        ser_pop = 1'b0;
    endtask

    task automatic push_pop(input logic [31:0] d, input string tag);
        bit exp_ack;
        bit room;
        exp_ack = run_m && (q.size() > 0);
        room = q.size() < DEPTH;
        bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = d; ser_pop = 1'b1;
        #1;
        chk({tag, " ack"}, 32'(ser_ack), 32'(exp_ack));
        if (exp_ack) chk({tag, " data"}, ser_data, q[0]);
        @(negedge clk);
        bus_wr = 1'b0; ser_pop = 1'b0;
        if (exp_ack) void'(q.pop_front());
        if (room) q.push_back(d);
    endtask

    task automatic check_status(input string tag);
        logic [31:0] v;
        bus_read(6'h14, v);
        chk({tag, " level"}, v, 32'(q.size()));
        bus_read(6'h04, v);
        chk({tag, " status"}, v, (32'(und_m) << 1) | 32'(q.size() <= wm_m));
        chk({tag, " irq"}, 32'(irq), 32'(exp_irq()));
        chk({tag, " dma_req"}, 32'(dma_req), 32'(exp_dma()));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0h expected %0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(6'h14, v); chk("R1 level", v, 0);
        bus_read(6'h04, v); chk("R1 status", v, 32'h1);
        bus_read(6'h00, v); chk("R1 ctrl", v, 0);
        bus_read(6'h08, v); chk("R1 xfer", v, 0);
        bus_read(6'h0C, v); chk("R1 flush", v, 0);
        bus_read(6'h10, v); chk("R1 dma", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 ack", 32'(ser_ack), 0);

        // R4 gate closed: no pops, no underrun
        push_w(32'hA000_0000); push_w(32'hA000_0001); push_w(32'hA000_0002);
        pop_chk("R4 stopped pop");
        check_status("R4 stopped");

        // R5 / R7 threshold
        ctrl_write(4, 1, 0, 0);
        check_status("R5 below wm");
        push_w(32'hA000_0003); push_w(32'hA000_0004);
        check_status("R5 above wm");

        // R2 ordered pops after start
        bus_write(6'h08, 32'h1); run_m = 1;
        for (int i = 0; i < 5; i++) pop_chk("R2 pop");
        check_status("R2 drained");

        // R6 underrun sticky and clear
        pop_chk("R6 empty pop");
        check_status("R6 set");
        ctrl_write(4, 0, 1, 0);
        check_status("R7 und irq");
        push_w(32'hB000_0000);
        check_status("R6 sticky");
        bus_read(6'h00, v); chk("R6 strobe reads 0", v & 32'h4, 0);
        ctrl_write(4, 0, 1, 1);
        check_status("R6 cleared");

        // R3 fill past full
        for (int i = 0; i < 40; i++) push_w(32'hC000_0000 + 32'(i));
        check_status("R3 full");
        push_pop(32'hDEAD_0001, "R3 full pair");
        check_status("R3 after full pair");
        push_pop(32'hDEAD_0002, "R10 pair");
        check_status("R10 level held");
        for (int i = 0; i < 3; i++) pop_chk("R2 order");

        // R8 flush
        bus_write(6'h0C, 32'h1);
        bus_read(6'h0C, v); chk("R8 flush busy", v, 1);
        bus_read(6'h0C, v); chk("R8 flush done", v, 0);
        q.delete();
        check_status("R8 empty");

        // R9 DMA request
        bus_write(6'h10, 32'h102); dma_en_m = 1; dma_lvl_m = 2;
        check_status("R9 low level");
        push_w(32'hE000_0000); push_w(32'hE000_0001); push_w(32'hE000_0002);
        check_status("R9 above");
        pop_chk("R9 pop");
        check_status("R9 at level");
        bus_write(6'h10, 32'h002); dma_en_m = 0;
        check_status("R9 disabled");

        // R4 stop again
        bus_write(6'h08, 32'h0); run_m = 0;
        pop_chk("R4 stop again");
        check_status("R4 stop hold");
        bus_write(6'h08, 32'h1); run_m = 1;

        // random mix
        ctrl_write(6, 1, 1, 0);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1, 2: push_w($urandom);
                3, 4:    pop_chk("R2 rnd pop");
                default: begin
                    check_status("R5 rnd");
                    if (und_m) ctrl_write(6, 1, 1, 1);
                end
            endcase
        end
        check_status("R7 rnd end");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule